// File: doc/BRIEF.md
# Temperature Limit Event Generator

This block keeps the most recent signed temperature sample and compares it with three programmable thresholds: a high limit, a low limit and a critical limit. The comparison is combinational against the stored sample and the current limit values. A limit write therefore changes the trip status and the alarm in the cycle after the write, with no need to wait for a fresh sample. The block presents a 16-bit data word that carries three trip flags above the 13-bit temperature. It also drives one alarm pin whose behaviour is set by a configuration register.

A host reaches the configuration and limit registers through a single-cycle write/read port. The read data is combinational from the address. Temperature samples arrive on a valid strobe from a converter pacer outside the block. While the shutdown bit is set, the block ignores these strobes and holds the last stored temperature. The alarm has two behaviours. In comparator mode it follows the present event condition. In interrupt mode it latches on a rising event condition and holds until the host writes a clear bit. Its active level is selectable. It stays at its inactive level until the host enables it.

Top module: `temp_alarm_unit`

## Requirements
- R1: After reset, `data_reg` is 0x0000, every register read at addresses 0 to 4 returns 0x0000, and `alarm_pin` is 1.
- R2: When `smp_vld` is high at a clock edge and shutdown is clear, `data_reg[12:0]` holds `smp_temp` from the following cycle. Otherwise it keeps its value. The value is two's complement, with bit 12 as sign and 0.0625 °C per LSB.
- R3: While configuration bit 4 (shutdown) is 1, sample strobes leave `data_reg[12:0]` unchanged. Reads of address 4 never alter the stored temperature.
- R4: Each limit register (high at address 1, low at 2, critical at 3) stores only write-data bits 12:2, in two's complement at 0.25 °C per LSB. It reads back with bits 15:13 and 1:0 as zero. For comparison it is taken as a 13-bit temperature with bits 1:0 zero.
- R5: `data_reg[15]` is 1 when temperature > critical limit. `data_reg[14]` is 1 when temperature > high limit. `data_reg[13]` is 1 when temperature < low limit. These flags do not depend on any configuration bit.
- R6: A limit write updates the trip flags, and the comparator-mode alarm, in the cycle after the write edge, with no new sample.
- R7: With configuration bit 0 (enable) set and bit 1 (mode) clear, the alarm is asserted exactly while the event condition holds. The event condition is any trip flag set.
- R8: Configuration bit 2 selects the polarity. When it is 1, asserted means 1 and deasserted means 0. When it is 0, asserted means 0 and deasserted means 1. While enable is 0, the pin sits at the deasserted level.
- R9: With configuration bit 3 (critical-only) set, the event condition is the critical flag alone.
- R10: With enable and mode both set, the alarm asserts one cycle after the event condition rises. It stays asserted until a configuration write with bit 5 set. A condition that is still true after the clear does not re-assert the alarm until it falls and rises again. Bit 5 always reads as 0.
- R11: Address 0 reads the configuration in bits 4:0, with the remaining bits zero. Address 4 reads `data_reg`. Writes to addresses 4 to 7 change nothing. Reads of addresses 5 to 7 return 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Temperature sample strobe |
| smp_temp | input | 13 | Signed sample, 0.0625 °C per LSB |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| data_reg | output | 16 | Trip flags 15:13 and temperature 12:0 |
| alarm_pin | output | 1 | Alarm output |

## Verification
The checker watches four things on every cycle: sample capture, the freeze under shutdown, comparator-mode agreement between the pin and the flags, and the inactive pin level while the alarm is disabled. It also checks that a latched interrupt cannot drop without a configuration write. Other behaviours need directed scenarios. These include the exact limit alignment and readback masking, and the signed comparisons on negative values. They also include re-evaluation triggered by a limit write and the critical-only restriction. Finally, they include the rule that a clear with the condition still present does not re-latch.

// File: rtl/tae_pkg.sv
package tae_pkg;
    localparam int TEMP_W   = 13;
    localparam int DATA_W   = 16;
    localparam int ADDR_W   = 3;
    localparam int LIM_LSB  = 2;
    localparam int NUM_LIM  = 3;
    localparam int FLAG_W   = DATA_W - TEMP_W;
    localparam int CLR_BIT  = 5;

    localparam int LIM_HIGH = 0;
    localparam int LIM_LOW  = 1;
    localparam int LIM_CRIT = 2;

    typedef logic signed [TEMP_W-1:0] temp_t;
    typedef logic [TEMP_W-1:LIM_LSB]  lim_f_t;

    typedef struct packed {
        logic shdn;
        logic crit_only;
        logic pol_hi;
        logic intr_mode;
        logic alarm_en;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

    typedef struct packed {
        logic above_crit;
        logic above_high;
        logic below_low;
    } trip_t;

    typedef enum logic [ADDR_W-1:0] {
        A_CFG  = 3'd0,
        A_HIGH = 3'd1,
        A_LOW  = 3'd2,
        A_CRIT = 3'd3,
        A_DATA = 3'd4
    } addr_e;

    function automatic temp_t align_limit(input lim_f_t f);
        return $signed({f, {LIM_LSB{1'b0}}});
    endfunction

    function automatic logic [DATA_W-1:0] limit_readback(input lim_f_t f);
        return {{FLAG_W{1'b0}}, f, {LIM_LSB{1'b0}}};
    endfunction
endpackage

// File: rtl/tae_regs.sv
module tae_regs
    import tae_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output cfg_t              cfg,
    output lim_f_t            lim [NUM_LIM],
    output logic              clr_pulse
);
    logic cfg_sel;
    logic unused_wbits;

    assign cfg_sel      = wr && (addr == A_CFG);
    assign clr_pulse    = cfg_sel && wdata[CLR_BIT];
    assign unused_wbits = ^wdata[DATA_W-1:TEMP_W];

    always_ff @(posedge clk) begin
        if (rst)
            cfg <= '0;
        else if (cfg_sel)
            cfg <= cfg_t'(wdata[CFG_W-1:0]);
    end

    for (genvar i = 0; i < NUM_LIM; i++) begin : g_lim
        logic sel;
        assign sel = wr && (addr == (ADDR_W'(A_HIGH) + ADDR_W'(i)));
        always_ff @(posedge clk) begin
            if (rst)
                lim[i] <= '0;
            else if (sel)
                lim[i] <= wdata[TEMP_W-1:LIM_LSB];
        end
    end
endmodule

// File: rtl/tae_cmp.sv
module tae_cmp
    import tae_pkg::*;
(
    input  temp_t  temp,
    input  lim_f_t lim [NUM_LIM],
    output trip_t  trip
);
    logic [NUM_LIM-1:0] hit;

    for (genvar i = 0; i < NUM_LIM; i++) begin : g_cmp
        temp_t thr;
        assign thr = align_limit(lim[i]);
        if (i == LIM_LOW) begin : g_below
            assign hit[i] = temp < thr;
        end else begin : g_above
            assign hit[i] = temp > thr;
        end
    end

    assign trip = '{above_crit: hit[LIM_CRIT],
                    above_high: hit[LIM_HIGH],
                    below_low:  hit[LIM_LOW]};
endmodule

// File: rtl/tae_alarm.sv
module tae_alarm
    import tae_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  cfg_t  cfg,
    input  trip_t trip,
    input  logic  clr,
    output logic  alarm_pin
);
    logic cond;
    logic cond_q;
    logic latched;
    logic active;

    assign cond = cfg.crit_only ? trip.above_crit : (|trip);

    always_ff @(posedge clk) begin
        if (rst) begin
            cond_q  <= 1'b0;
            latched <= 1'b0;
        end else begin
            cond_q <= cond;
            if (!(cfg.alarm_en && cfg.intr_mode))
                latched <= 1'b0;
            else if (cond && !cond_q)
                latched <= 1'b1;
            else if (clr)
                latched <= 1'b0;
        end
    end

    assign active    = cfg.intr_mode ? latched : cond;
    assign alarm_pin = (cfg.alarm_en && active) ? cfg.pol_hi : !cfg.pol_hi;
endmodule

// File: rtl/temp_alarm_unit.sv
module temp_alarm_unit
    import tae_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_vld,
    input  logic [TEMP_W-1:0] smp_temp,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [DATA_W-1:0] data_reg,
    output logic              alarm_pin
);
    cfg_t   cfg_q;
    lim_f_t lim_q [NUM_LIM];
    logic   clr_pulse;
    temp_t  temp_q;
    trip_t  trip;

    tae_regs i_regs (
        .clk       (clk),
        .rst       (rst),
        .wr        (reg_wr),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .cfg       (cfg_q),
        .lim       (lim_q),
        .clr_pulse (clr_pulse)
    );

    always_ff @(posedge clk) begin
        if (rst)
            temp_q <= '0;
        else if (smp_vld && !cfg_q.shdn)
            temp_q <= smp_temp;
    end

    tae_cmp i_cmp (
        .temp (temp_q),
        .lim  (lim_q),
        .trip (trip)
    );

    tae_alarm i_alarm (
        .clk       (clk),
        .rst       (rst),
        .cfg       (cfg_q),
        .trip      (trip),
        .clr       (clr_pulse),
        .alarm_pin (alarm_pin)
    );

    assign data_reg = {trip, temp_q};

    always_comb begin
        case (reg_addr)
            A_CFG:   reg_rdata = {{(DATA_W-CFG_W){1'b0}}, cfg_q};
            A_HIGH:  reg_rdata = limit_readback(lim_q[LIM_HIGH]);
            A_LOW:   reg_rdata = limit_readback(lim_q[LIM_LOW]);
            A_CRIT:  reg_rdata = limit_readback(lim_q[LIM_CRIT]);
            A_DATA:  reg_rdata = data_reg;
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tae_chk.sv
module tae_chk
    import tae_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              smp_vld,
    input logic [TEMP_W-1:0] smp_temp,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] data_reg,
    input logic              alarm_pin,
    input cfg_t              cfg
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (data_reg == '0) && alarm_pin);

    // R2
    sample_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (smp_vld && !cfg.shdn) |=> (data_reg[TEMP_W-1:0] == $past(smp_temp)));

    // R3
    shutdown_hold_chk: assert property (@(posedge clk) disable iff (rst)
        cfg.shdn |=> $stable(data_reg[TEMP_W-1:0]));

    // R7
    comparator_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg.alarm_en && !cfg.intr_mode && !cfg.crit_only) |->
        ((alarm_pin == cfg.pol_hi) == (|data_reg[DATA_W-1:TEMP_W])));

    // R8
    disabled_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg.alarm_en |-> (alarm_pin == !cfg.pol_hi));

    // R10
    intr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg.alarm_en && cfg.intr_mode && (alarm_pin == cfg.pol_hi) &&
         !(reg_wr && reg_addr == A_CFG)) |=> (alarm_pin == $past(alarm_pin)));
endmodule

bind temp_alarm_unit tae_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .smp_vld   (smp_vld),
    .smp_temp  (smp_temp),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .data_reg  (data_reg),
    .alarm_pin (alarm_pin),
    .cfg       (cfg_q)
);

// File: tb/test_temp_alarm_unit.sv
module test_temp_alarm_unit;
    localparam int TICK_DIV = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_vld = 1'b0;
    logic [12:0] smp_temp = '0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [15:0] data_reg;
    logic        alarm_pin;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    logic signed [12:0] m_temp = '0;
    logic [15:0]        m_lim [3] = '{16'h0, 16'h0, 16'h0};
    bit                 m_shdn = 0;

    temp_alarm_unit i_temp_alarm_unit (
        .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_temp(smp_temp),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .data_reg(data_reg), .alarm_pin(alarm_pin)
    );

    always #4 clk = ~clk;

    function automatic logic signed [12:0] lim_al(input logic [15:0] v);
        return $signed(v[12:0] & 13'h1FFC);
    endfunction

    function automatic logic [15:0] exp_data();
        logic c, h, l;
        c = m_temp > lim_al(m_lim[2]);
        h = m_temp > lim_al(m_lim[0]);
        l = m_temp < lim_al(m_lim[1]);
        return {c, h, l, m_temp};
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        if (a >= 3'd1 && a <= 3'd3) m_lim[a-1] = d;
        if (a == 3'd0) m_shdn = d[4];
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic smp(input logic [12:0] t);
        repeat (TICK_DIV - 1) @(negedge clk);
        smp_vld = 1'b1; smp_temp = t;
        @(negedge clk);
        smp_vld = 1'b0;
        if (!m_shdn) m_temp = $signed(t);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        check("R1 data", data_reg, 16'h0);
        check("R1 pin", {15'h0, alarm_pin}, 16'h1);
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), v);
            check("R1 read", v, 16'h0);
        end
    endtask

    task automatic t_sample();
        smp(13'h0190);
        check("R2 positive", data_reg, exp_data());
        check("R5 flags zero limits", data_reg[15:13], 3'b110);
        smp(13'h1F00);
        check("R2 negative", data_reg, exp_data());
        check("R5 below low", data_reg[15:13], 3'b001);
    endtask

    task automatic t_limits();
        logic [15:0] v;
        wr(3'd3, 16'hFFFF);
        rd(3'd3, v);
        check("R4 readback mask", v, 16'h1FFC);
        smp(13'h0000);
        check("R4 crit above -0.25C", data_reg, exp_data());
        check("R4 crit flag", {13'h0, data_reg[15:13]}, 16'h4);
        wr(3'd1, 16'h01E0);
        wr(3'd2, 16'h1F00);
        wr(3'd3, 16'h0550);
        smp(13'h0190);
        check("R5 in window", data_reg, {3'b000, 13'h0190});
        wr(3'd1, 16'h00C8);
        check("R6 write raises high", data_reg, exp_data());
        check("R6 high flag", {13'h0, data_reg[15:13]}, 16'h2);
        wr(3'd1, 16'h01E0);
        check("R6 write clears high", data_reg, {3'b000, 13'h0190});
    endtask

    task automatic t_shutdown();
        logic [15:0] v;
        wr(3'd0, 16'h0010);
        smp(13'h0400);
        check("R3 held in shutdown", data_reg, {3'b000, 13'h0190});
        for (int k = 0; k < 3; k++) rd(3'd4, v);
        check("R3 read no effect", v, {3'b000, 13'h0190});
        wr(3'd0, 16'h0000);
        smp(13'h0230);
        check("R3 resumes", data_reg, exp_data());
        check("R3 resumes flag", {13'h0, data_reg[15:13]}, 16'h2);
        smp(13'h0190);
    endtask

    task automatic t_comparator();
        wr(3'd0, 16'h0001);
        check("R7 idle active-low", {15'h0, alarm_pin}, 16'h1);
        smp(13'h0230);
        check("R7 asserted low", {15'h0, alarm_pin}, 16'h0);
        wr(3'd0, 16'h0005);
        check("R8 active-high asserted", {15'h0, alarm_pin}, 16'h1);
        smp(13'h1ED4);
        check("R7 below low", {15'h0, alarm_pin}, 16'h1);
        check("R5 below low flag", data_reg, exp_data());
        smp(13'h0190);
        check("R7 clears", {15'h0, alarm_pin}, 16'h0);
        wr(3'd1, 16'h00C8);
        check("R6 limit write alarms", {15'h0, alarm_pin}, 16'h1);
        wr(3'd1, 16'h01E0);
        wr(3'd0, 16'h0004);
        smp(13'h0230);
        check("R8 disabled high pol", {15'h0, alarm_pin}, 16'h0);
        wr(3'd0, 16'h0000);
        check("R8 disabled low pol", {15'h0, alarm_pin}, 16'h1);
        check("R5 flags ignore config", data_reg, exp_data());
    endtask

    task automatic t_critonly();
        wr(3'd0, 16'h000D);
        check("R9 high only no alarm", {15'h0, alarm_pin}, 16'h0);
        smp(13'h0578);
        check("R9 crit alarms", {15'h0, alarm_pin}, 16'h1);
        check("R9 flags", data_reg, exp_data());
        smp(13'h0190);
        check("R9 back", {15'h0, alarm_pin}, 16'h0);
    endtask

    task automatic t_interrupt();
        logic [15:0] v;
        wr(3'd0, 16'h0007);
        smp(13'h0230);
        check("R10 not yet latched", {15'h0, alarm_pin}, 16'h0);
        @(negedge clk);
        check("R10 latched", {15'h0, alarm_pin}, 16'h1);
        smp(13'h0190);
        repeat (3) @(negedge clk);
        check("R10 holds", {15'h0, alarm_pin}, 16'h1);
        wr(3'd0, 16'h0027);
        check("R10 cleared", {15'h0, alarm_pin}, 16'h0);
        rd(3'd0, v);
        check("R10 clear bit reads 0", v, 16'h0007);
        wr(3'd1, 16'h00C8);
        @(negedge clk);
        check("R6 limit write latches", {15'h0, alarm_pin}, 16'h1);
        wr(3'd0, 16'h0027);
        repeat (3) @(negedge clk);
        check("R10 no relatch", {15'h0, alarm_pin}, 16'h0);
        wr(3'd1, 16'h01E0);
        wr(3'd0, 16'h0000);
    endtask

    task automatic t_map();
        logic [15:0] v;
        wr(3'd4, 16'hFFFF);
        wr(3'd6, 16'h1234);
        check("R11 data unchanged", data_reg, {3'b000, 13'h0190});
        rd(3'd6, v);
        check("R11 unmapped read", v, 16'h0);
        rd(3'd1, v);
        check("R11 high intact", v, 16'h01E0);
        rd(3'd4, v);
        check("R11 data read", v, data_reg);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_sample();
        t_limits();
        t_shutdown();
        t_comparator();
        t_critonly();
        t_interrupt();
        t_map();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule